// File: doc/BRIEF.md
# Three-Byte to Four-Pixel Stream Unpacker

This block sits between a processor output port and a video output stage. The processor packs four 6-bit colour pixels (64 colours each) into three consecutive bytes. A group of four pixels therefore costs three port writes instead of four. The block unpacks that byte stream and hands one pixel to the video stage each time the pixel-clock enable allows it. Horizontal and vertical sync come from separate timing hardware, so no bit of the byte stream is spent on sync.

A small residual register keeps the bits a byte leaves over until the next byte completes a pixel. A two-bit group counter tracks which of the three bytes comes next. A line-start pulse realigns the counter at the beginning of each scan line, so a stray or lost byte cannot shift colours beyond the end of the line. Completed pixels wait in a two-slot holding stage until a pixel enable releases them. A byte that arrives while a pixel would still be waiting is refused, and a sticky flag records the refusal.

Top module: `pix3to4_unpack`

## Requirements
- R1: The stream is little-end first. Let w be the 24-bit word formed by byte0 in bits 7:0, byte1 in bits 15:8 and byte2 in bits 23:16. Pixel k of the group is then w[6k+5:6k], so pixel 0 is byte0[5:0], pixel 1 is {byte1[3:0], byte0[7:6]}, pixel 2 is {byte2[1:0], byte1[7:4]} and pixel 3 is byte2[7:2].
- R2: Pixels leave in stream order. A clock edge with `pix_en` high and at least one waiting pixel puts the oldest one on `pix_out`, with `pix_valid` high for exactly the following cycle. At all other times `pix_valid` is low and `pix_out` holds its last value.
- R3: The third byte of a group completes two pixels at once. The first leaves on the next enabled edge. The second waits for a later enabled edge.
- R4: While `pix_en` stays low, no pixel is emitted and waiting pixels are kept unchanged.
- R5: An edge with `line_start` high drops any waiting pixels and leftover bits, returns the group counter to byte 0, and emits no pixel on that edge.
- R6: A byte presented on the same edge as `line_start` is taken as byte 0 of a new group.
- R7: A byte that arrives without `line_start` is refused when a pixel would remain waiting after that edge's emission. A refused byte is discarded without changing the group position, the leftover bits or the waiting pixels, and it sets `overrun`.
- R8: Once set, `overrun` stays high through line starts and clears only on reset.
- R9: While `rst_n` is low, `pix_valid`, `pix_out` and `overrun` read zero, and the group counter restarts at byte 0.
- R10: With `pix_en` held high, a stream that sends three bytes on consecutive cycles followed by one idle cycle per group runs indefinitely without overrun and delivers four pixels per group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Realigns the group to byte 0 and flushes waiting pixels |
| byte_valid | input | 1 | `byte_in` carries a stream byte this cycle |
| byte_in | input | BYTE_W (8) | Packed stream byte |
| pix_en | input | 1 | Pixel-clock enable from the video stage |
| pix_out | output | PIX_W (6) | Unpacked pixel |
| pix_valid | output | 1 | `pix_out` carries a new pixel this cycle |
| overrun | output | 1 | Sticky flag: a byte was refused |

## Verification
Several properties are checked on every cycle. The holding stage never exceeds two pixels and the group counter never leaves its three legal values. A valid pixel always follows an enabled edge that had a waiting pixel. A line start leaves the block empty, or holding exactly one pixel when a byte came with it. The overrun flag rises only on a byte edge and never falls. The bit layout, the stream order across groups, the deferred second pixel of a group, and the proof that a refused byte leaves the stream intact can only be shown by the bench's scenarios. The bench compares the block against a bit-accumulating model on every clock and also checks pixel lists worked out in advance.

// File: rtl/pix3to4_pkg.sv
package pix3to4_pkg;

   localparam int DEF_PIX_W  = 6;
   localparam int DEF_BYTE_W = 8;
   localparam int GRP_BYTES  = 3;
   localparam int GRP_PIX    = 4;
   localparam int HOLD_DEPTH = 2;
   localparam int HOLD_CNT_W = $clog2(HOLD_DEPTH + 1);

   typedef enum logic [1:0] {
      PH_FIRST = 2'd0,
      PH_MID   = 2'd1,
      PH_LAST  = 2'd2
   } grp_phase_e;

   function automatic grp_phase_e phase_next(grp_phase_e p);
      case (p)
         PH_FIRST: return PH_MID;
         PH_MID:   return PH_LAST;
         default:  return PH_FIRST;
      endcase
   endfunction

endpackage

// File: rtl/pix3to4_slicer.sv
module pix3to4_slicer
   import pix3to4_pkg::*;
#(
   parameter int PIX_W  = DEF_PIX_W,
   parameter int BYTE_W = DEF_BYTE_W,
   localparam int R1    = BYTE_W - PIX_W,
   localparam int RES_W = 2 * R1
) (
   input  grp_phase_e          phase,
   input  logic [RES_W-1:0]    resid,
   input  logic [BYTE_W-1:0]   byte_in,
   output logic [PIX_W-1:0]    pix_a,
   output logic [PIX_W-1:0]    pix_b,
   output logic                two_pix,
   output logic [RES_W-1:0]    resid_nxt
);

   always_comb begin
      pix_a     = '0;
      pix_b     = '0;
      two_pix   = 1'b0;
      resid_nxt = '0;
      unique case (phase)
         PH_FIRST: begin
            pix_a              = byte_in[PIX_W-1:0];
            resid_nxt[R1-1:0]  = byte_in[BYTE_W-1:PIX_W];
         end
         PH_MID: begin
            pix_a              = {byte_in[PIX_W-R1-1:0], resid[R1-1:0]};
            resid_nxt          = byte_in[BYTE_W-1:PIX_W-R1];
         end
         PH_LAST: begin
            pix_a              = {byte_in[PIX_W-RES_W-1:0], resid};
            pix_b              = byte_in[BYTE_W-1:PIX_W-RES_W];
            two_pix            = 1'b1;
         end
         default: begin
            pix_a              = '0;
         end
      endcase
   end

endmodule

// File: rtl/pix3to4_phase.sv
module pix3to4_phase
   import pix3to4_pkg::*;
#(
   parameter int RES_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              accept,
   input  logic [RES_W-1:0]  resid_nxt,
   output grp_phase_e        phase_q,
   output grp_phase_e        eff_phase,
   output logic [RES_W-1:0]  eff_resid
);

   logic [RES_W-1:0] resid_q;

   assign eff_phase = line_start ? PH_FIRST : phase_q;
   assign eff_resid = line_start ? '0 : resid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_FIRST;
         resid_q <= '0;
      end else if (accept) begin
         phase_q <= phase_next(eff_phase);
         resid_q <= resid_nxt;
      end else if (line_start) begin
         phase_q <= PH_FIRST;
         resid_q <= '0;
      end
   end

endmodule

// File: rtl/pix3to4_hold.sv
module pix3to4_hold
   import pix3to4_pkg::*;
#(
   parameter int PIX_W = DEF_PIX_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  line_start,
   input  logic                  pix_en,
   input  logic                  accept,
   input  logic [PIX_W-1:0]      pix_a,
   input  logic [PIX_W-1:0]      pix_b,
   input  logic                  two_pix,
   output logic [HOLD_CNT_W-1:0] cnt_q,
   output logic                  blocked,
   output logic [PIX_W-1:0]      pix_out,
   output logic                  pix_valid
);

   logic [PIX_W-1:0]      head_q;
   logic [PIX_W-1:0]      tail_q;
   logic                  emit;
   logic [HOLD_CNT_W-1:0] left;

   assign emit    = !line_start && pix_en && (cnt_q != '0);
   assign left    = cnt_q - {{(HOLD_CNT_W-1){1'b0}}, emit};
   assign blocked = (left != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q    <= '0;
         tail_q    <= '0;
         cnt_q     <= '0;
         pix_out   <= '0;
         pix_valid <= 1'b0;
      end else begin
         if (accept) begin
            head_q <= pix_a;
            tail_q <= pix_b;
            cnt_q  <= two_pix ? HOLD_CNT_W'(2) : HOLD_CNT_W'(1);
         end else if (line_start) begin
            cnt_q  <= '0;
         end else if (emit) begin
            head_q <= tail_q;
            cnt_q  <= cnt_q - HOLD_CNT_W'(1);
         end
         pix_valid <= emit;
         if (emit) begin
            pix_out <= head_q;
         end
      end
   end

endmodule

// File: rtl/pix3to4_unpack.sv
module pix3to4_unpack
   import pix3to4_pkg::*;
#(
   parameter int PIX_W  = DEF_PIX_W,
   parameter int BYTE_W = DEF_BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              pix_en,
   output logic [PIX_W-1:0]  pix_out,
   output logic              pix_valid,
   output logic              overrun
);

   localparam int R1    = BYTE_W - PIX_W;
   localparam int RES_W = 2 * R1;

   if (GRP_PIX * PIX_W != GRP_BYTES * BYTE_W) begin : g_bad_ratio
      $error("pix3to4_unpack: four pixels must fill exactly three bytes");
   end
   if (R1 <= 0 || RES_W >= PIX_W) begin : g_bad_split
      $error("pix3to4_unpack: pixel width must sit between half and full byte width");
   end

   grp_phase_e            phase_q;
   grp_phase_e            eff_phase;
   logic [RES_W-1:0]      eff_resid;
   logic [RES_W-1:0]      resid_nxt;
   logic [PIX_W-1:0]      pix_a;
   logic [PIX_W-1:0]      pix_b;
   logic                  two_pix;
   logic [HOLD_CNT_W-1:0] pend_cnt;
   logic                  blocked;
   logic                  accept;
   logic                  refuse;

   assign accept = byte_valid && (line_start || !blocked);
   assign refuse = byte_valid && !line_start && blocked;

   pix3to4_phase #(.RES_W(RES_W)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .accept     (accept),
      .resid_nxt  (resid_nxt),
      .phase_q    (phase_q),
      .eff_phase  (eff_phase),
      .eff_resid  (eff_resid)
   );

   pix3to4_slicer #(.PIX_W(PIX_W), .BYTE_W(BYTE_W)) u_slicer (
      .phase     (eff_phase),
      .resid     (eff_resid),
      .byte_in   (byte_in),
      .pix_a     (pix_a),
      .pix_b     (pix_b),
      .two_pix   (two_pix),
      .resid_nxt (resid_nxt)
   );

   pix3to4_hold #(.PIX_W(PIX_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .pix_en     (pix_en),
      .accept     (accept),
      .pix_a      (pix_a),
      .pix_b      (pix_b),
      .two_pix    (two_pix),
      .cnt_q      (pend_cnt),
      .blocked    (blocked),
      .pix_out    (pix_out),
      .pix_valid  (pix_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         overrun <= 1'b0;
      end else if (refuse) begin
         overrun <= 1'b1;
      end
   end

endmodule

// File: rtl/pix3to4_unpack_chk.sv
module pix3to4_unpack_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       line_start,
   input logic       byte_valid,
   input logic       pix_en,
   input logic       pix_valid,
   input logic       overrun,
   input logic [1:0] pend_cnt,
   input logic [1:0] phase
);

   // R3
   hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt != 2'd3);

   // R6
   phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase != 2'd3);

   // R2
   valid_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> ($past(pix_en) && $past(pend_cnt) != 2'd0));

   // R5
   line_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !byte_valid) |=> (phase == 2'd0 && pend_cnt == 2'd0 && !pix_valid));

   // R6
   line_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && byte_valid) |=> (phase == 2'd1 && pend_cnt == 2'd1 && !pix_valid));

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R7
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(byte_valid && !line_start));

endmodule

bind pix3to4_unpack pix3to4_unpack_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_start (line_start),
   .byte_valid (byte_valid),
   .pix_en     (pix_en),
   .pix_valid  (pix_valid),
   .overrun    (overrun),
   .pend_cnt   (pend_cnt),
   .phase      (phase_q)
);

// File: tb/pix3to4_unpack_bench.sv
module pix3to4_unpack_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ls = 1'b0;
   logic       bv = 1'b0;
   logic [7:0] bin = 8'h00;
   logic       pe = 1'b0;
   logic [5:0] pix_out;
   logic       pix_valid;
   logic       overrun;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pix3to4_unpack u_pix3to4_unpack (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (ls),
      .byte_valid (bv),
      .byte_in    (bin),
      .pix_en     (pe),
      .pix_out    (pix_out),
      .pix_valid  (pix_valid),
      .overrun    (overrun)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reference model: a bit accumulator, little-end first (R1)
   logic [5:0]  mq[$];
   logic [15:0] macc;
   int          mnb;
   logic [5:0]  mo;
   bit          mv;
   bit          movr;

   task automatic m_push(input logic [7:0] b);
      macc = macc | (16'(b) << mnb);
      mnb += 8;
      while (mnb >= 6) begin
         mq.push_back(macc[5:0]);
         macc = macc >> 6;
         mnb -= 6;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); macc = '0; mnb = 0; mo = '0; mv = 0; movr = 0;
      end else if (ls) begin
         mq.delete(); macc = '0; mnb = 0; mv = 0;
         if (bv) m_push(bin);
      end else begin
         if (pe && mq.size() > 0) begin
            mo = mq.pop_front();
            mv = 1;
         end else begin
            mv = 0;
         end
         if (bv) begin
            if (mq.size() != 0) movr = 1;
            else m_push(bin);
         end
      end
   end

   logic [5:0] got[$];

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(pix_valid == mv, "R2 lockstep pix_valid", pix_valid, mv);
         if (mv) chk(pix_out == mo, "R1 lockstep pix_out", pix_out, mo);
         chk(overrun == movr, "R7 lockstep overrun", overrun, movr);
         if (pix_valid) got.push_back(pix_out);
      end
   end

   task automatic step(input bit l, input bit v, input logic [7:0] b, input bit e);
      ls = l; bv = v; bin = b; pe = e;
      @(negedge clk);
   endtask

   function automatic logic [23:0] pack4(input logic [5:0] p0, p1, p2, p3);
      return {p3, p2, p1, p0};
   endfunction

   task automatic send_group(input logic [23:0] w, input bit e);
      step(0, 1, w[7:0], e);
      step(0, 1, w[15:8], e);
      step(0, 1, w[23:16], e);
      step(0, 0, 8'h00, e);
   endtask

   task automatic drain();
      repeat (5) step(0, 0, 8'h00, 1);
      step(0, 0, 8'h00, 0);
   endtask

   task automatic check_px(input string req, input int idx, input logic [5:0] e);
      int act;
      act = (got.size() > idx) ? int'(got[idx]) : -1;
      chk(act == int'(e), req, act, e);
   endtask

   task automatic check_group(input string req, input int base, input logic [23:0] w);
      for (int k = 0; k < 4; k++) check_px(req, base + k, w[6*k +: 6]);
   endtask

   initial begin
      repeat (3000000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++;
         $display("FAIL R0 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [23:0] wa, wb, wc;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(pix_valid == 0, "R9 reset pix_valid", pix_valid, 0);
      chk(pix_out == 0, "R9 reset pix_out", pix_out, 0);
      chk(overrun == 0, "R9 reset overrun", overrun, 0);
      rst_n = 1;
      step(0, 0, 8'h00, 0);

      // R1 bit layout: bytes 95 FA 07 carry 15 2A 3F 01
      got.delete();
      wa = pack4(6'h15, 6'h2A, 6'h3F, 6'h01);
      chk(wa == 24'h07FA95, "R1 packing helper", wa, 24'h07FA95);
      send_group(wa, 1);
      drain();
      chk(got.size() == 4, "R1 pixel count", got.size(), 4);
      check_group("R1 layout", 0, wa);

      // R10 sustained 3+1 cadence, R2 order across groups
      got.delete();
      for (int g = 0; g < 3; g++) begin
         wb = pack4(6'(g*4+1), 6'(g*4+34), 6'(g*4+3), 6'(63-g));
         send_group(wb, 1);
      end
      drain();
      chk(overrun == 0, "R10 no overrun at full cadence", overrun, 0);
      chk(got.size() == 12, "R10 pixel count", got.size(), 12);
      for (int g = 0; g < 3; g++) begin
         wb = pack4(6'(g*4+1), 6'(g*4+34), 6'(g*4+3), 6'(63-g));
         check_group("R2 stream order", 4*g, wb);
      end

      // R4 hold with enable low, R3 deferred second pixel
      got.delete();
      wc = pack4(6'h3C, 6'h03, 6'h2D, 6'h12);
      step(0, 1, wc[7:0], 0);
      repeat (4) step(0, 0, 8'h00, 0);
      chk(got.size() == 0, "R4 no emission while enable low", got.size(), 0);
      step(0, 0, 8'h00, 1);
      step(0, 1, wc[15:8], 0);
      step(0, 0, 8'h00, 1);
      step(0, 1, wc[23:16], 0);
      repeat (3) step(0, 0, 8'h00, 0);
      chk(got.size() == 2, "R4 held pixels not emitted", got.size(), 2);
      step(0, 0, 8'h00, 1);
      repeat (3) step(0, 0, 8'h00, 0);
      chk(got.size() == 3, "R3 second pixel waits for enable", got.size(), 3);
      step(0, 0, 8'h00, 1);
      step(0, 0, 8'h00, 0);
      chk(got.size() == 4, "R3 second pixel released", got.size(), 4);
      check_group("R3 values", 0, wc);

      // R5 line start mid-group drops waiting pixel and residual
      got.delete();
      step(0, 1, wa[7:0], 1);
      step(0, 1, wa[15:8], 1);
      step(1, 0, 8'h00, 1);
      repeat (3) step(0, 0, 8'h00, 1);
      chk(got.size() == 1, "R5 waiting pixel dropped", got.size(), 1);
      check_px("R5 first pixel kept", 0, wa[5:0]);
      send_group(wc, 1);
      drain();
      chk(got.size() == 5, "R5 realigned count", got.size(), 5);
      check_group("R5 realigned group", 1, wc);

      // R6 byte with line start is byte 0
      got.delete();
      step(0, 1, wc[7:0], 1);
      step(1, 1, wa[7:0], 1);
      step(0, 1, wa[15:8], 1);
      step(0, 1, wa[23:16], 1);
      drain();
      chk(got.size() == 4, "R6 count", got.size(), 4);
      check_group("R6 group", 0, wa);
      chk(overrun == 0, "R6 no overrun", overrun, 0);

      // R7 refused byte discarded, earlier data kept
      got.delete();
      step(0, 1, wc[7:0], 0);
      step(0, 1, 8'hFF, 0);
      chk(overrun == 1, "R7 overrun set", overrun, 1);
      step(0, 0, 8'h00, 1);
      step(0, 1, wc[15:8], 1);
      step(0, 1, wc[23:16], 1);
      drain();
      chk(got.size() == 4, "R7 count after refusal", got.size(), 4);
      check_group("R7 stream intact", 0, wc);

      // R8 sticky through line start, cleared by reset
      step(1, 0, 8'h00, 1);
      repeat (3) step(0, 0, 8'h00, 1);
      chk(overrun == 1, "R8 overrun survives line start", overrun, 1);
      rst_n = 0;
      step(0, 0, 8'h00, 0);
      chk(overrun == 0, "R8 overrun cleared by reset", overrun, 0);
      chk(pix_valid == 0, "R9 reset mid-run", pix_valid, 0);
      rst_n = 1;
      step(0, 0, 8'h00, 0);

      // mixed traffic against the model (R2 R5 R7)
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 40) == 0, ($urandom % 3) == 0, 8'($urandom), ($urandom % 4) != 0);
      end
      drain();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule